// File: doc/BRIEF.md
# AU-4 Pointer Interpreter with Automatic AIS Insertion

This block watches a byte-wide STM-1 stream and reads the AU-4 pointer in the third pointer row to find the VC-4 payload. The input is one byte per clock, together with the byte's row (0 to 8) and column (0 to 269) inside the 9 x 270 frame. From each frame's pointer word it keeps a current payload offset. It marks every byte that carries payload, flags the first byte of the VC-4 (the J1 position), and follows positive and negative justification.

A three-state tracker decides whether the pointer can be trusted. In the normal state, payload is marked. In the path-AIS state, an all-ones pointer has been seen. In the loss-of-pointer state, the pointer could not be followed. Whenever the tracker is not in the normal state, or the force input is high, the block replaces every AU-4 byte on its output with all ones, and the payload and J1 marks stay low. Section overhead bytes outside the pointer row always pass through unchanged.

Top module: `au4_ptr_interp`

## Requirements
- R1: While reset is high, and on the first output after it, the tracker is in loss-of-pointer: `lop_o`=1, `au_ais_o`=0, `ais_ins_o`=1, `ptr_o`=0, and `pay_valid_o` and `j1_o` are 0.
- R2: H1 is the byte at row 3 column 0 and H2 is the byte at row 3 column 3. The NDF field is H1[7:4]. The 10-bit offset is {H1[1:0],H2}, and only offsets from 0 to 782 are valid. NDF counts as normal within one bit of 0110, and as set within one bit of 1001. Each output reflects the byte presented one clock earlier. A tracker decision takes effect from the byte after H2.
- R3: Payload bytes are those in columns 9 to 269 of every row. Payload bytes are counted from 0, starting at row 3 column 9 and running through rows 4 to 8 and then rows 0 to 2 of the following frame. In the normal state, with force low, `pay_valid_o` marks payload bytes, and `j1_o` marks payload byte number 3 x offset.
- R4: In the AIS or LOP state, three consecutive frames that carry the same valid offset with normal NDF move the tracker to the normal state with that offset.
- R5: In the normal state, a different valid offset with normal NDF is adopted only on its third consecutive identical arrival. The first two arrivals leave the offset unchanged.
- R6: In the normal state, a set NDF with a valid offset adopts that offset at once.
- R7: Value bits 9, 7, 5, 3 and 1 are the I bits, and bits 8, 6, 4, 2 and 0 are the D bits. With normal NDF, if at least 3 I bits are inverted relative to the current offset and fewer than 3 D bits are, the frame is an increment. The offset then rises by one, and row 3 columns 9 to 11 of that frame carry no payload. The mirror-image case is a decrement. The offset then falls by one, and row 3 columns 6 to 8 of that frame carry payload.
- R8: During the three frames after an accepted increment or decrement, another increment or decrement pattern leaves the offset unchanged, and the frame counts as invalid.
- R9: In the normal state, eight consecutive frames that are neither all-ones, a matching offset, an accepted adjustment, an accepted set-NDF frame nor a confirming third arrival move the tracker to LOP. The offset is kept.
- R10: Eight consecutive set-NDF frames in the normal state move the tracker to LOP. The eighth frame's value is not adopted.
- R11: Three consecutive frames with H1 and H2 both 0xFF move the tracker to AIS. The `lop_o` and `au_ais_o` flags are never high together.
- R12: When the tracker is not normal, or `force_ais_i` is high, every byte in row 3 columns 0 to 269 and every byte in columns 9 to 269 of the other rows is output as 0xFF. All other bytes pass unchanged. In that case `ais_ins_o`=1 and `pay_valid_o`=`j1_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Received byte |
| row_i | input | 4 | Row of `din`, 0 to 8 |
| col_i | input | 9 | Column of `din`, 0 to 269 |
| force_ais_i | input | 1 | Requests all-ones insertion |
| dout_o | output | 8 | Outgoing byte, with AIS applied |
| pay_valid_o | output | 1 | Outgoing byte is VC-4 payload |
| j1_o | output | 1 | Outgoing byte is the first VC-4 byte |
| ptr_o | output | 10 | Current payload offset |
| lop_o | output | 1 | Loss-of-pointer alarm |
| au_ais_o | output | 1 | Path AIS alarm |
| ais_ins_o | output | 1 | All-ones insertion active |

## Verification
The tracker's decision and the marking of the byte stream meet at the H2 byte. A new state, offset or justification is clocked in on H2, and the very next byte must already follow it, while H2 itself and the bytes before it follow the previous frame's decision. The bench provokes this with pointer sequences that enter and leave AIS and LOP, accept increments, decrements and new offsets, and assert force during a normal frame. For every byte it predicts output data, payload mark, J1 mark, offset and alarms, switching from the previous frame's expectation to the new one exactly at the byte after H2. A one-byte slip in either direction shows as a mismatch on that boundary.

// File: rtl/au4p_pkg.sv
package au4p_pkg;
    localparam int ROWS     = 9;
    localparam int COLS     = 270;
    localparam int OH_COLS  = 9;
    localparam int PTR_ROW  = 3;
    localparam int H1_COL   = 0;
    localparam int H2_COL   = 3;
    localparam int UNIT     = 3;
    localparam int PAY_COLS = COLS - OH_COLS;
    localparam int UNITS    = ROWS * PAY_COLS / UNIT;
    localparam int MAX_PTR  = UNITS - 1;
    localparam int PW       = 10;

    localparam logic [PW-1:0] I_MASK     = 10'h2AA;
    localparam logic [PW-1:0] D_MASK     = 10'h155;
    localparam logic [3:0]    NDF_NORMAL = 4'b0110;
    localparam logic [3:0]    NDF_SET    = 4'b1001;

    typedef enum logic [1:0] {ST_NORM = 2'd0, ST_AIS = 2'd1, ST_LOP = 2'd2} pst_e;
    typedef enum logic [1:0] {ADJ_NONE = 2'd0, ADJ_INC = 2'd1, ADJ_DEC = 2'd2} adj_e;

    typedef struct packed {
        logic          all1;
        logic          ndf_set;
        logic          ndf_norm;
        logic          in_rng;
        logic          same;
        logic          inc;
        logic          dec;
        logic [PW-1:0] val;
    } pevt_t;

    function automatic int ones(input logic [PW-1:0] v);
        int n = 0;
        for (int i = 0; i < PW; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic near4(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] d = a ^ b;
        return (int'(d[0]) + int'(d[1]) + int'(d[2]) + int'(d[3])) <= 1;
    endfunction

    localparam int MAJ = ones(I_MASK) / 2 + 1;
endpackage

// File: rtl/au4p_classify.sv
module au4p_classify
    import au4p_pkg::*;
(
    input  logic [3:0]    ndf,
    input  logic [1:0]    vhi,
    input  logic [7:0]    vlo,
    input  logic [PW-1:0] ptr,
    output pevt_t         ev
);
    logic [PW-1:0] val, diff;
    int iflip, dflip;

    always_comb begin
        val   = {vhi, vlo};
        diff  = val ^ ptr;
        iflip = ones(diff & I_MASK);
        dflip = ones(diff & D_MASK);
        ev.val      = val;
        ev.all1     = (ndf == 4'hF) && (vhi == 2'b11) && (vlo == 8'hFF);
        ev.ndf_set  = near4(ndf, NDF_SET);
        ev.ndf_norm = near4(ndf, NDF_NORMAL);
        ev.in_rng   = int'(val) <= MAX_PTR;
        ev.same     = (val == ptr);
        ev.inc      = ev.ndf_norm && !ev.same && iflip >= MAJ && dflip < MAJ;
        ev.dec      = ev.ndf_norm && !ev.same && dflip >= MAJ && iflip < MAJ;
    end
endmodule

// File: rtl/au4p_fsm.sv
module au4p_fsm
    import au4p_pkg::*;
#(
    parameter int AIS_FRAMES  = 3,
    parameter int LOP_FRAMES  = 8,
    parameter int NEW_FRAMES  = 3,
    parameter int HOLD_FRAMES = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h2_tick,
    input  pevt_t         ev,
    output pst_e          st,
    output logic [PW-1:0] ptr,
    output adj_e          adj
);
    localparam int AW = $clog2(AIS_FRAMES + 1);
    localparam int LW = $clog2(LOP_FRAMES + 1);
    localparam int NW = $clog2(NEW_FRAMES + 1);
    localparam int HW = $clog2(HOLD_FRAMES + 1);

    logic [AW-1:0] ais_cnt;
    logic [LW-1:0] inv_cnt, ndf_cnt;
    logic [NW-1:0] cand_cnt, cand_nxt;
    logic [HW-1:0] hold;
    logic [PW-1:0] cand, ptr_up, ptr_dn;
    logic          cand_done, cand_ok, ais_last, inv_last, ndf_last;

    always_comb begin
        cand_nxt  = (cand_cnt != '0 && ev.val == cand) ? cand_cnt + 1'b1 : NW'(1);
        cand_done = (cand_nxt == NW'(NEW_FRAMES));
        cand_ok   = ev.ndf_norm && ev.in_rng && !ev.inc && !ev.dec;
        ais_last  = (ais_cnt == AW'(AIS_FRAMES - 1));
        inv_last  = (inv_cnt == LW'(LOP_FRAMES - 1));
        ndf_last  = (ndf_cnt == LW'(LOP_FRAMES - 1));
        ptr_up    = (ptr == PW'(MAX_PTR)) ? '0 : ptr + 1'b1;
        ptr_dn    = (ptr == '0) ? PW'(MAX_PTR) : ptr - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_LOP; ptr <= '0; adj <= ADJ_NONE; hold <= '0;
            ais_cnt <= '0; inv_cnt <= '0; ndf_cnt <= '0; cand_cnt <= '0; cand <= '0;
        end else if (h2_tick) begin
            adj <= ADJ_NONE;
            if (hold != '0) hold <= hold - 1'b1;
            if (ev.all1) begin
                inv_cnt <= '0; ndf_cnt <= '0; cand_cnt <= '0;
                if (st != ST_AIS) begin
                    if (ais_last) begin st <= ST_AIS; ais_cnt <= '0; end
                    else ais_cnt <= ais_cnt + 1'b1;
                end
            end else begin
                ais_cnt <= '0;
                if (st == ST_NORM) begin
                    if (ev.ndf_set && ev.in_rng) begin
                        inv_cnt <= '0; cand_cnt <= '0;
                        if (ndf_last) begin st <= ST_LOP; ndf_cnt <= '0; end
                        else begin ptr <= ev.val; ndf_cnt <= ndf_cnt + 1'b1; end
                    end else if (ev.ndf_norm && ev.same) begin
                        inv_cnt <= '0; ndf_cnt <= '0; cand_cnt <= '0;
                    end else if (ev.inc && hold == '0) begin
                        ptr <= ptr_up; adj <= ADJ_INC; hold <= HW'(HOLD_FRAMES);
                        inv_cnt <= '0; ndf_cnt <= '0; cand_cnt <= '0;
                    end else if (ev.dec && hold == '0) begin
                        ptr <= ptr_dn; adj <= ADJ_DEC; hold <= HW'(HOLD_FRAMES);
                        inv_cnt <= '0; ndf_cnt <= '0; cand_cnt <= '0;
                    end else begin
                        ndf_cnt <= '0;
                        if (cand_ok && cand_done) begin
                            ptr <= ev.val; cand_cnt <= '0; inv_cnt <= '0;
                        end else begin
                            if (cand_ok) begin cand <= ev.val; cand_cnt <= cand_nxt; end
                            else cand_cnt <= '0;
                            if (inv_last) begin st <= ST_LOP; inv_cnt <= '0; end
                            else inv_cnt <= inv_cnt + 1'b1;
                        end
                    end
                end else begin
                    if (ev.ndf_norm && ev.in_rng) begin
                        if (cand_done) begin
                            st <= ST_NORM; ptr <= ev.val; hold <= '0;
                            cand_cnt <= '0; inv_cnt <= '0; ndf_cnt <= '0;
                        end else begin
                            cand <= ev.val; cand_cnt <= cand_nxt;
                        end
                    end else cand_cnt <= '0;
                end
            end
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) <= MAX_PTR); // R2
    AST_STATE_AT_H2: assert property (@(posedge clk) disable iff (rst)
        (st != $past(st)) |-> $past(h2_tick)); // R4
endmodule

// File: rtl/au4p_mapper.sv
module au4p_mapper
    import au4p_pkg::*;
#(
    parameter int RW  = 4,
    parameter int CLW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     din,
    input  logic [RW-1:0]  row,
    input  logic [CLW-1:0] col,
    input  logic           force_ais,
    input  pst_e           st,
    input  logic [PW-1:0]  ptr,
    input  adj_e           adj,
    output logic [7:0]     dout_o,
    output logic           pay_valid_o,
    output logic           j1_o,
    output logic [PW-1:0]  ptr_o,
    output logic           lop_o,
    output logic           au_ais_o,
    output logic           ais_ins_o
);
    int   r, c, idx;
    logic au, pay, j1_hit, ins, mark;

    always_comb begin
        r      = int'(row);
        c      = int'(col);
        idx    = ((r >= PTR_ROW) ? r - PTR_ROW : r + ROWS - PTR_ROW) * PAY_COLS + c - OH_COLS;
        au     = (c >= OH_COLS) || (r == PTR_ROW);
        pay    = ((c >= OH_COLS) && !(r == PTR_ROW && adj == ADJ_INC && c < OH_COLS + UNIT))
              || (r == PTR_ROW && adj == ADJ_DEC && c >= OH_COLS - UNIT && c < OH_COLS);
        j1_hit = (c >= OH_COLS) && (idx == int'(ptr) * UNIT);
        ins    = (st != ST_NORM) || force_ais;
        mark   = !ins;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= '0; pay_valid_o <= 1'b0; j1_o <= 1'b0; ptr_o <= '0;
            lop_o <= 1'b1; au_ais_o <= 1'b0; ais_ins_o <= 1'b1;
        end else begin
            dout_o      <= (ins && au) ? 8'hFF : din;
            pay_valid_o <= mark && pay;
            j1_o        <= mark && j1_hit;
            ptr_o       <= ptr;
            lop_o       <= (st == ST_LOP);
            au_ais_o    <= (st == ST_AIS);
            ais_ins_o   <= ins;
        end
    end

    AST_J1_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        j1_o |-> pay_valid_o); // R3
    AST_INS_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        ais_ins_o |-> (!pay_valid_o && !j1_o)); // R12
    AST_ALARM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lop_o && au_ais_o)); // R11
endmodule

// File: rtl/au4_ptr_interp.sv
module au4_ptr_interp
    import au4p_pkg::*;
#(
    parameter int RW          = 4,
    parameter int CLW         = 9,
    parameter int AIS_FRAMES  = 3,
    parameter int LOP_FRAMES  = 8,
    parameter int NEW_FRAMES  = 3,
    parameter int HOLD_FRAMES = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     din,
    input  logic [RW-1:0]  row_i,
    input  logic [CLW-1:0] col_i,
    input  logic           force_ais_i,
    output logic [7:0]     dout_o,
    output logic           pay_valid_o,
    output logic           j1_o,
    output logic [PW-1:0]  ptr_o,
    output logic           lop_o,
    output logic           au_ais_o,
    output logic           ais_ins_o
);
    logic [5:0]    h1_q;
    logic          h1_tick, h2_tick;
    pevt_t         ev;
    pst_e          st;
    adj_e          adj;
    logic [PW-1:0] ptr;

    assign h1_tick = (int'(row_i) == PTR_ROW) && (int'(col_i) == H1_COL);
    assign h2_tick = (int'(row_i) == PTR_ROW) && (int'(col_i) == H2_COL);

    always_ff @(posedge clk) begin
        if (rst)          h1_q <= '0;
        else if (h1_tick) h1_q <= {din[7:4], din[1:0]};
    end

    au4p_classify u_cls (
        .ndf(h1_q[5:2]), .vhi(h1_q[1:0]), .vlo(din), .ptr(ptr), .ev(ev)
    );

    au4p_fsm #(
        .AIS_FRAMES(AIS_FRAMES), .LOP_FRAMES(LOP_FRAMES),
        .NEW_FRAMES(NEW_FRAMES), .HOLD_FRAMES(HOLD_FRAMES)
    ) u_fsm (
        .clk(clk), .rst(rst), .h2_tick(h2_tick), .ev(ev),
        .st(st), .ptr(ptr), .adj(adj)
    );

    au4p_mapper #(.RW(RW), .CLW(CLW)) u_map (
        .clk(clk), .rst(rst), .din(din), .row(row_i), .col(col_i),
        .force_ais(force_ais_i), .st(st), .ptr(ptr), .adj(adj),
        .dout_o(dout_o), .pay_valid_o(pay_valid_o), .j1_o(j1_o), .ptr_o(ptr_o),
        .lop_o(lop_o), .au_ais_o(au_ais_o), .ais_ins_o(ais_ins_o)
    );
endmodule

// File: tb/sim_au4_ptr_interp.sv
module sim_au4_ptr_interp;
    localparam int NORM = 0, AIS = 1, LOP = 2;
    localparam int INC = 1, DEC = 2;

    logic       clk = 1'b0, rst = 1'b1, force_ais = 1'b0;
    logic [7:0] din = '0;
    logic [3:0] row = '0;
    logic [8:0] col = '0;
    logic [7:0] dout;
    logic       pv, j1, lop, ais, ins;
    logic [9:0] ptr;

    always #2 clk = ~clk;

    au4_ptr_interp u0 (
        .clk(clk), .rst(rst), .din(din), .row_i(row), .col_i(col),
        .force_ais_i(force_ais), .dout_o(dout), .pay_valid_o(pv), .j1_o(j1),
        .ptr_o(ptr), .lop_o(lop), .au_ais_o(ais), .ais_ins_o(ins)
    );

    typedef struct packed {
        logic [7:0]  dout;
        logic        pv, j1;
        logic [9:0]  ptr;
        logic        lop, ais, ins;
        logic [31:0] tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, fails = 0, fnum = 0;
    int   pst = LOP;
    int   pptr = 0;

    task automatic chk(input bit ok, input logic [31:0] tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: outputs settle after the edge that captured the queued byte
    initial forever begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(dout == e.dout, e.tag, "dout", int'(dout), int'(e.dout));
            chk(pv == e.pv,     e.tag, "pay_valid", int'(pv), int'(e.pv));
            chk(j1 == e.j1,     e.tag, "j1", int'(j1), int'(e.j1));
            chk(ptr == e.ptr,   e.tag, "ptr", int'(ptr), int'(e.ptr));
            chk(lop == e.lop,   e.tag, "lop", int'(lop), int'(e.lop));
            chk(ais == e.ais,   e.tag, "au_ais", int'(ais), int'(e.ais));
            chk(ins == e.ins,   e.tag, "ais_ins", int'(ins), int'(e.ins));
        end
    end

    // driver: one whole frame, with the tracker result expected after its H2
    task automatic send_frame(input logic [3:0] ndf, input int val, input bit all1,
                              input bit frc, input int est, input int eptr,
                              input int eadj, input logic [31:0] tag);
        fnum++;
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 270; c++) begin
                exp_t e;
                logic [7:0] d;
                bit after, au, norm, pay;
                int s, p, a, idx;
                d = 8'((r * 17 + c * 5 + fnum * 3) & 255);
                if (r == 3 && c == 0) d = all1 ? 8'hFF : {ndf, 2'b10, 2'(val >> 8)};
                if (r == 3 && c == 3) d = all1 ? 8'hFF : 8'(val & 255);
                after = (r > 3) || (r == 3 && c > 3);
                s = after ? est : pst;
                p = after ? eptr : pptr;
                a = after ? eadj : 0;
                @(negedge clk);
                din = d; row = 4'(r); col = 9'(c); force_ais = frc;
                au   = (c >= 9) || (r == 3);
                norm = (s == NORM) && !frc;
                pay  = ((c >= 9) && !(r == 3 && a == INC && c < 12))
                    || (r == 3 && a == DEC && c >= 6 && c < 9);
                idx  = ((r >= 3) ? r - 3 : r + 6) * 261 + c - 9;
                e.dout = (!norm && au) ? 8'hFF : d;
                e.pv   = norm && pay;
                e.j1   = norm && (c >= 9) && (idx == 3 * p);
                e.ptr  = 10'(p);
                e.lop  = (s == LOP);
                e.ais  = (s == AIS);
                e.ins  = !norm;
                e.tag  = tag;
                q.push_back(e);
            end
        end
        pst = est; pptr = eptr;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired after %0d checks", checks);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(lop == 1'b1, "R1", "reset lop", int'(lop), 1);
        chk(ais == 1'b0, "R1", "reset au_ais", int'(ais), 0);
        chk(ins == 1'b1, "R1", "reset ais_ins", int'(ins), 1);
        chk(ptr == 10'd0, "R1", "reset ptr", int'(ptr), 0);
        chk(pv == 1'b0 && j1 == 1'b0, "R1", "reset marks", int'({pv, j1}), 0);
        @(negedge clk);
        rst = 1'b0;
        // leave LOP after three identical offsets
        send_frame(4'b0110, 100, 0, 0, LOP, 0, 0, "R4");
        send_frame(4'b0110, 100, 0, 0, LOP, 0, 0, "R4");
        send_frame(4'b0110, 100, 0, 0, NORM, 100, 0, "R4");
        send_frame(4'b0110, 100, 0, 0, NORM, 100, 0, "R3");
        // increment, blocked increment, decrement
        send_frame(4'b0110, 100 ^ 'h2AA, 0, 0, NORM, 101, INC, "R7");
        send_frame(4'b0110, 101 ^ 'h2AA, 0, 0, NORM, 101, 0, "R8");
        send_frame(4'b0110, 101, 0, 0, NORM, 101, 0, "R2");
        send_frame(4'b0110, 101, 0, 0, NORM, 101, 0, "R2");
        send_frame(4'b0110, 101 ^ 'h155, 0, 0, NORM, 100, DEC, "R7");
        // new offset after three arrivals
        send_frame(4'b0110, 500, 0, 0, NORM, 100, 0, "R5");
        send_frame(4'b0110, 500, 0, 0, NORM, 100, 0, "R5");
        send_frame(4'b0110, 500, 0, 0, NORM, 500, 0, "R5");
        // set NDF with one bit in error
        send_frame(4'b1011, 300, 0, 0, NORM, 300, 0, "R6");
        send_frame(4'b0110, 300, 0, 0, NORM, 300, 0, "R6");
        // path AIS in and out
        send_frame(4'hF, 0, 1, 0, NORM, 300, 0, "R11");
        send_frame(4'hF, 0, 1, 0, NORM, 300, 0, "R11");
        send_frame(4'hF, 0, 1, 0, AIS, 300, 0, "R11");
        send_frame(4'b0110, 300, 0, 0, AIS, 300, 0, "R12");
        send_frame(4'b0110, 300, 0, 0, AIS, 300, 0, "R12");
        send_frame(4'b0110, 300, 0, 0, NORM, 300, 0, "R4");
        // eight invalid offsets
        for (int k = 0; k < 7; k++) send_frame(4'b0110, 1000, 0, 0, NORM, 300, 0, "R9");
        send_frame(4'b0110, 1000, 0, 0, LOP, 300, 0, "R9");
        send_frame(4'b0110, 200, 0, 0, LOP, 300, 0, "R4");
        send_frame(4'b0110, 200, 0, 0, LOP, 300, 0, "R4");
        send_frame(4'b0110, 200, 0, 0, NORM, 200, 0, "R4");
        // forced insertion in a normal frame
        send_frame(4'b0110, 200, 0, 1, NORM, 200, 0, "R12");
        // eight set-NDF frames
        for (int k = 1; k <= 7; k++) send_frame(4'b1001, 10 * k, 0, 0, NORM, 10 * k, 0, "R10");
        send_frame(4'b1001, 80, 0, 0, LOP, 70, 0, "R10");
        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule